// File: doc/BRIEF.md
# Programmable fault flag debouncer

A bank of fault-flag qualifiers. Each flag watches one raw fault condition. A flag is set only after its condition has stayed high without a break for a chosen number of timebase ticks. It drops in the same cycle that the condition goes low. Each flag has its own table of four tick counts, and any entry may be zero. A select field picks the entry in use. Some flags have only two choices, and for those the upper select bit has no effect.

The default tables assume a 40 ns tick and fill the bank as follows:
- Flag 0: supply overvoltage.
- Flag 1: output overvoltage.
- Flag 2: fast current-sense overcurrent.
- Flag 3: slow overcurrent.
- Flag 4: reverse current.

Flag 0 also has a force-clear input. While that input is high, flag 0 is held low and its qualification starts over. An integrator overrides the tables to suit its own tick period. Whatever acts on the flags afterwards lies outside this block.

Top module: `fault_debounce_bank`

## Requirements
- R1: A flag whose selected tick count T is nonzero goes high in the cycle after the clock edge that samples the T-th tick (tick_i high) seen while its condition has been continuously high. With a tick every cycle, the flag is therefore high in the (T+1)-th consecutive cycle of the condition.
- R2: A flag is low in every cycle in which its condition input is low. Clearing has no delay.
- R3: If the condition drops for even one cycle, the tick count for that flag restarts from zero.
- R4: If the selected tick count is zero, the flag equals its condition in the same cycle, through logic with no register.
- R5: The select field of flag i is sel_i[2i+1:2i]. The value s in that field chooses entry s (0 to 3) of the table for that flag.
- R6: Flags marked as two-choice (flags 0 and 4 by default) use only sel_i[2i]. Bit 2i+1 is ignored.
- R7: While force_clr_i is high, flag 0 is low and its tick count is held at zero. After release, flag 0 needs its full tick count again before it sets. Other flags are not affected by force_clr_i.
- R8: Cycles in which tick_i is low do not advance any count.
- R9: During reset, every count is zero, and every flag whose selected count is nonzero is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| cond_i | input | NF | Raw fault conditions, one per flag |
| sel_i | input | 2*NF | Select field per flag, flag i at bits [2i+1:2i] |
| force_clr_i | input | 1 | Holds flag 0 cleared |
| flag_o | output | NF | Qualified fault flags |

## Verification
A count that does not reset when the condition drops shows at flag_o as a flag that sets too early after a short glitch. This appears within the first tick count following the interruption. A select decoded wrongly shows as the flag setting after the wrong number of ticks, or at once when it should wait. A held bit that outlives its condition, or that survives force-clear, shows at the ports in the very cycle the condition falls or force-clear is released. The bench therefore compares the whole flag vector in every cycle.

// File: rtl/fault_debounce_bank.sv
module fault_debounce_bank #(
  parameter int NF = 5,
  parameter int CNT_W = 25,
  parameter logic [NF-1:0] ONE_BIT_SEL = 5'b10001,
  parameter int FORCE_IDX = 0,
  parameter logic [NF*4*CNT_W-1:0] DLY_TABLE = {
    25'd5,        25'd5,       25'd5,      25'd1,
    25'd25000000, 25'd5000000, 25'd500000, 25'd0,
    25'd3,        25'd2,       25'd1,      25'd0,
    25'd200,      25'd56,      25'd24,     25'd0,
    25'd12500,    25'd12500,   25'd12500,  25'd50
  }
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic [NF-1:0]   cond_i,
  input  logic [2*NF-1:0] sel_i,
  input  logic            force_clr_i,
  output logic [NF-1:0]   flag_o
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    logic [1:0]       sel;
    logic [CNT_W-1:0] tgt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   nxt;
    logic             held;
    logic             blk;

    assign sel = ONE_BIT_SEL[i] ? {1'b0, sel_i[2*i]} : sel_i[2*i+1 -: 2];
    assign tgt = DLY_TABLE[(i*4 + int'(sel))*CNT_W +: CNT_W];
    assign blk = (i == FORCE_IDX) && force_clr_i;
    assign nxt = {1'b0, cnt} + 1'b1;

    always_ff @(posedge clk) begin
      if (!rst_n || !cond_i[i] || blk) begin
        cnt  <= '0;
        held <= 1'b0;
      end else if (tick_i && !held) begin
        cnt <= nxt[CNT_W-1:0];
        if (nxt >= {1'b0, tgt}) held <= 1'b1;
      end
    end

    assign flag_o[i] = cond_i[i] & ~blk & (held | (tgt == '0));

    assert_clear_immediate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cond_i[i] |-> !flag_o[i]);
    assert_set_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flag_o[i]) && tgt != '0) |-> $past(tick_i));
    assert_held_needs_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
      held |-> $past(cond_i[i]));
    if (i == FORCE_IDX) begin : g_frc
      assert_force_holds_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        force_clr_i |-> !flag_o[i]);
    end
  end
endmodule

// File: tb/fault_debounce_bank_tb.sv
module fault_debounce_bank_tb_top;
  localparam int CLK_P = 10;
  localparam int NF = 5;
  localparam logic [NF*4*25-1:0] TB_TABLE = {
    25'd20, 25'd20, 25'd5, 25'd1,
    25'd8,  25'd4,  25'd2, 25'd0,
    25'd3,  25'd2,  25'd1, 25'd0,
    25'd4,  25'd2,  25'd1, 25'd0,
    25'd20, 25'd20, 25'd5, 25'd2
  };

  logic clk = 0, rst_n = 0, tick = 0, frc = 0;
  logic [NF-1:0] cond = '0;
  logic [2*NF-1:0] sel = '0;
  logic [NF-1:0] flag;

  typedef struct { logic [NF-1:0] exp; string tag; } item_t;
  item_t q[$];
  event smp;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  fault_debounce_bank #(.NF(NF), .CNT_W(25), .DLY_TABLE(TB_TABLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .cond_i(cond), .sel_i(sel),
    .force_clr_i(frc), .flag_o(flag));

  task automatic step(input logic [NF-1:0] c, input logic t, input logic f,
                      input logic [NF-1:0] e, input string tag);
    item_t it;
    @(negedge clk);
    cond = c; tick = t; frc = f;
    it.exp = e; it.tag = tag;
    q.push_back(it);
    #(CLK_P/4);
    ->smp;
  endtask

  initial forever begin
    item_t it;
    @smp;
    it = q.pop_front();
    checks++;
    if (flag !== it.exp) begin
      fails++;
      $display("FAIL %s: flag=%b expected=%b", it.tag, flag, it.exp);
    end
  end

  task automatic run(input logic [NF-1:0] c, input int n, input int hi_at,
                     input logic [NF-1:0] m, input string tag);
    for (int k = 0; k < n; k++) step(c, 1'b1, 1'b0, (k >= hi_at) ? m : '0, tag);
  endtask

  initial begin
    step('0, 1'b1, 1'b0, '0, "R9 reset");
    step(5'b11111, 1'b1, 1'b0, 5'b01110, "R9 reset zero entries");
    step('0, 1'b1, 1'b0, '0, "R9 reset");
    rst_n = 1;
    step('0, 1'b1, 1'b0, '0, "R9 after reset");
    sel[3:2] = 2'd0;
    step(5'b00010, 1'b1, 1'b0, 5'b00010, "R4 zero entry passthru");
    step(5'b00000, 1'b1, 1'b0, 5'b00000, "R2 zero entry clear");
    sel[3:2] = 2'd3;
    run(5'b00010, 6, 4, 5'b00010, "R1 R5 flag1 sel3 T=4");
    step(5'b00000, 1'b1, 1'b0, 5'b00000, "R2 immediate clear");
    sel[3:2] = 2'd2;
    step(5'b00010, 1'b1, 1'b0, '0, "R3 before glitch");
    step(5'b00000, 1'b1, 1'b0, '0, "R3 glitch");
    run(5'b00010, 3, 2, 5'b00010, "R3 restart T=2");
    step('0, 1'b1, 1'b0, '0, "R2");
    sel[5:4] = 2'd3;
    step(5'b00100, 1'b0, 1'b0, '0, "R8 no tick");
    step(5'b00100, 1'b1, 1'b0, '0, "R8 tick1");
    step(5'b00100, 1'b0, 1'b0, '0, "R8 no tick");
    step(5'b00100, 1'b1, 1'b0, '0, "R8 tick2");
    step(5'b00100, 1'b1, 1'b0, '0, "R8 tick3");
    step(5'b00100, 1'b0, 1'b0, 5'b00100, "R8 set after 3 ticks");
    step('0, 1'b1, 1'b0, '0, "R2");
    sel[9:8] = 2'b10;
    run(5'b10000, 3, 1, 5'b10000, "R6 flag4 upper bit ignored");
    step('0, 1'b1, 1'b0, '0, "R2");
    sel[9:8] = 2'b11;
    run(5'b10000, 7, 5, 5'b10000, "R6 R5 flag4 entry1 T=5");
    step('0, 1'b1, 1'b0, '0, "R2");
    sel[1:0] = 2'b10;
    run(5'b00001, 4, 2, 5'b00001, "R6 flag0 upper bit ignored T=2");
    for (int k = 0; k < 4; k++) step(5'b00001, 1'b1, 1'b1, '0, "R7 forced low");
    step(5'b00001, 1'b1, 1'b0, '0, "R7 release restart");
    step(5'b00001, 1'b1, 1'b0, '0, "R7 release restart");
    step(5'b00001, 1'b1, 1'b0, 5'b00001, "R7 set after full count");
    step(5'b00001, 1'b1, 1'b1, '0, "R7 force drops set flag");
    sel[3:2] = 2'd0;
    step(5'b00011, 1'b1, 1'b1, 5'b00010, "R7 other flags unaffected");
    step('0, 1'b1, 1'b0, '0, "R2");
    sel[7:6] = 2'd3;
    run(5'b01000, 10, 8, 5'b01000, "R1 R5 flag3 T=8");
    step('0, 1'b1, 1'b0, '0, "R2 final");
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P*100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule